// File: doc/BRIEF.md
# Tiled Rectangle Fill and Copy Engine

This block paints axis-aligned rectangles into a frame buffer of 16-bit pixels. The buffer is laid out as 16x16 pixel tiles, so a pixel's word address interleaves its x and y bits. A command either floods the rectangle with one color or copies a rectangle of source pixels into it. In copy mode, zero-valued source pixels can optionally be treated as transparent and left unwritten. The destination may be walked backwards on either axis, which mirrors the image; the source is always read forwards.

A sequencer presents the command word, its parameter words, the clip limits and the two base configuration words, then pulses `start`. The engine samples everything on that edge. It then visits one pixel per cycle in row-major order and issues at most one memory write per cycle. In copy mode it also issues one read per visited pixel. Reads complete after a fixed latency, and a small in-flight queue keeps each destination address in step with its data. `busy` covers the whole operation, and `done` pulses once when it ends.

Top module: `rect_blit`

## Requirements
- R1: The word offset of pixel (x, y) is x[3:0] in bits 3:0, y[3:0] in bits 7:4, x[15:4] from bit 8 upward and y[15:4] from bit 13 upward, truncated to AW bits.
- R2: The destination address is dst_cfg[6:0]·2^15 plus the offset. The source address is src_cfg[6:0]·2^15 + src_cfg[15:13]·2^12 plus the offset of the source pixel.
- R3: Fill mode (cmd[15:11] == 2) writes color prm8 to every pixel of the rectangle whose corners are (prm0, prm1) and (prm4, prm5), both corners included.
- R4: On each axis the destination steps +1 when end ≥ start (signed), and −1 otherwise. In copy mode the source offset always grows from the origin (prm0, prm1).
- R5: A pixel is written only if 0 ≤ x ≤ clip_x and 0 ≤ y ≤ clip_y, all compared as signed 16-bit. A rectangle lying wholly outside the clip window writes nothing but still completes.
- R6: In copy mode, cmd[9] = 1 skips source pixels equal to zero, and cmd[9] = 0 writes every pixel. Fill mode writes its color even when that color is zero and cmd[9] is set.
- R7: Pixels are written in row-major order: x is the inner loop, and rows follow the y step direction.
- R8: After reset, busy, done, rd_en and wr_en are low. An accepted start makes busy high on the next cycle. Busy stays high until the cycle after the last write, and done pulses for exactly one cycle as busy falls.
- R9: A start pulse while busy is high is ignored. The running operation's results and write count are unchanged.
- R10: Any opcode cmd[15:11] other than 2 selects copy mode, with source origin (prm0, prm1), destination start (prm4, prm5) and destination end (prm8, prm9).
- R11: A copy reads each in-clip source pixel once. It writes the returned data, RD_LAT cycles after the read, to the matching destination, and loses no pixel at a rate of one pixel per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| cmd | input | 16 | Command word: opcode in 15:11, transparency in bit 9 |
| prm0 | input | 16 | Parameter word 0 |
| prm1 | input | 16 | Parameter word 1 |
| prm4 | input | 16 | Parameter word 4 |
| prm5 | input | 16 | Parameter word 5 |
| prm8 | input | 16 | Parameter word 8 |
| prm9 | input | 16 | Parameter word 9 |
| clip_x | input | 16 | Inclusive right clip limit (signed) |
| clip_y | input | 16 | Inclusive bottom clip limit (signed) |
| dst_cfg | input | 16 | Destination base configuration word |
| src_cfg | input | 16 | Source base configuration word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at completion |
| rd_en | output | 1 | Source read request |
| rd_addr | output | AW | Source word address |
| rd_data | input | 16 | Read data, valid RD_LAT cycles after rd_en |
| wr_en | output | 1 | Frame-buffer write strobe |
| wr_addr | output | AW | Write word address |
| wr_data | output | 16 | Write data |

## Verification
The engine is driven with forward, x-mirrored and fully mirrored rectangles. These show whether the step direction and the row-major order come out right. Placing source and destination in separate tiles, plus spans that cross tile edges, exposes errors in the bit interleave or the base arithmetic. Clip windows that cut a rectangle, exclude it entirely, or reduce it to a single pixel test the signed bounds. Copies with and without transparency over a source containing zeros, a start pulse injected mid-operation, and seeded random commands check that written data, write count and write order each agree with a bench model.

// File: rtl/rect_blit.sv
module rect_blit #(
  parameter int AW = 22,
  parameter int RD_LAT = 2,
  parameter logic [4:0] FILL_OP = 5'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   cmd,
  input  logic [15:0]   prm0,
  input  logic [15:0]   prm1,
  input  logic [15:0]   prm4,
  input  logic [15:0]   prm5,
  input  logic [15:0]   prm8,
  input  logic [15:0]   prm9,
  input  logic [15:0]   clip_x,
  input  logic [15:0]   clip_y,
  input  logic [15:0]   dst_cfg,
  input  logic [15:0]   src_cfg,
  output logic          busy,
  output logic          done,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);

  function automatic logic [31:0] swz(input logic [15:0] x, input logic [15:0] y);
    return {28'd0, x[3:0]} | {24'd0, y[3:0], 4'd0} |
           {12'd0, x[15:4], 8'd0} | {7'd0, y[15:4], 13'd0};
  endfunction

  logic              run, fm, tp, busy_d;
  logic [15:0]       x0, cx, cy, ex, ey, ox, oy, ix, iy, col, clx, cly;
  logic              nx, ny;
  logic [6:0]        dcfg;
  logic [9:0]        scfg;
  logic [RD_LAT:0]   pv;
  logic [AW-1:0]     pa [RD_LAT+1];

  wire        is_fill = cmd[15:11] == FILL_OP;
  wire [15:0] in_sx = is_fill ? prm0 : prm4;
  wire [15:0] in_sy = is_fill ? prm1 : prm5;
  wire [15:0] in_ex = is_fill ? prm4 : prm8;
  wire [15:0] in_ey = is_fill ? prm5 : prm9;

  wire [31:0] dbase = {10'd0, dcfg, 15'd0};
  wire [31:0] sbase = {10'd0, scfg[6:0], 15'd0} | {17'd0, scfg[9:7], 12'd0};
  wire [31:0] dsum  = dbase + swz(cx, cy);
  wire [31:0] ssum  = sbase + swz(ox + ix, oy + iy);
  wire [AW-1:0] daddr = dsum[AW-1:0];

  wire vis = ~cx[15] & ($signed(cx) <= $signed(clx)) &
             ~cy[15] & ($signed(cy) <= $signed(cly));
  wire [15:0] stx = nx ? 16'hFFFF : 16'h0001;
  wire [15:0] sty = ny ? 16'hFFFF : 16'h0001;
  wire fwr  = run & fm & vis;
  wire crd  = run & ~fm & vis;
  wire cwr  = pv[RD_LAT] & ((|rd_data) | ~tp);

  logic unused_bits;
  assign unused_bits = ^{cmd[10], cmd[8:0], dst_cfg[15:7], src_cfg[12:7],
                         dsum[31:AW], ssum[31:AW]};

  assign busy = run | (|pv) | wr_en;
  assign done = busy_d & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; fm <= 1'b0; tp <= 1'b0; busy_d <= 1'b0;
      x0 <= '0; cx <= '0; cy <= '0; ex <= '0; ey <= '0;
      ox <= '0; oy <= '0; ix <= '0; iy <= '0; col <= '0;
      clx <= '0; cly <= '0; nx <= 1'b0; ny <= 1'b0;
      dcfg <= '0; scfg <= '0;
    end else begin
      busy_d <= busy;
      if (start && !busy) begin
        run  <= 1'b1;
        fm   <= is_fill;
        tp   <= cmd[9];
        x0   <= in_sx; cx <= in_sx; cy <= in_sy;
        ex   <= in_ex; ey <= in_ey;
        nx   <= $signed(in_ex) < $signed(in_sx);
        ny   <= $signed(in_ey) < $signed(in_sy);
        ox   <= prm0; oy <= prm1; ix <= '0; iy <= '0;
        col  <= prm8;
        clx  <= clip_x; cly <= clip_y;
        dcfg <= dst_cfg[6:0];
        scfg <= {src_cfg[15:13], src_cfg[6:0]};
      end else if (run) begin
        if (cx == ex) begin
          cx <= x0;
          ix <= '0;
          if (cy == ey) run <= 1'b0;
          else begin
            cy <= cy + sty;
            iy <= iy + 16'd1;
          end
        end else begin
          cx <= cx + stx;
          ix <= ix + 16'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      pv      <= '0;
      for (int i = 0; i <= RD_LAT; i++) pa[i] <= '0;
    end else begin
      rd_en   <= crd;
      rd_addr <= ssum[AW-1:0];
      pv[0]   <= crd;
      pa[0]   <= daddr;
      for (int i = 1; i <= RD_LAT; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
      end
      wr_en   <= fwr | cwr;
      wr_addr <= fwr ? daddr : pa[RD_LAT];
      wr_data <= fwr ? col : rd_data;
    end
  end

endmodule

module rect_blit_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic rd_en,
  input logic wr_en
);
  // R8
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R11
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!wr_en && !rd_en));
endmodule

bind rect_blit rect_blit_chk u_chk (.*);

// File: tb/rect_blit_tb.sv
module rect_blit_tb;
  localparam int AW = 22;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] cmd = '0, prm0 = '0, prm1 = '0, prm4 = '0, prm5 = '0, prm8 = '0, prm9 = '0;
  logic [15:0] clip_x = '0, clip_y = '0, dst_cfg = '0, src_cfg = '0;
  logic busy, done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  rect_blit #(.AW(AW), .RD_LAT(LAT)) u_dut (.*);

  logic [15:0] mem [int];
  int wq [$];
  int eq [$];
  logic [15:0] ev [$];
  logic [15:0] rp [LAT];

  function automatic logic [15:0] bg(int a);
    logic [15:0] h;
    h = 16'((a * 40503) ^ (a >> 3));
    return (a % 5 == 0) ? 16'h0000 : (h | 16'h0001);
  endfunction

  function automatic logic [15:0] rdm(int a);
    return mem.exists(a) ? mem[a] : bg(a);
  endfunction

  function automatic int bswz(int x, int y);
    int xu, yu, r;
    xu = x & 16'hFFFF; yu = y & 16'hFFFF;
    r = (xu & 15) | ((yu & 15) << 4) | ((xu >> 4) << 8) | ((yu >> 4) << 13);
    return r & ((1 << AW) - 1);
  endfunction

  always @(posedge clk) begin
    rp[0] <= rd_en ? rdm(int'(rd_addr)) : 16'h0000;
    for (int i = 1; i < LAT; i++) rp[i] <= rp[i-1];
    if (wr_en) begin
      mem[int'(wr_addr)] = wr_data;
      wq.push_back(int'(wr_addr));
    end
  end
  assign rd_data = rp[LAT-1];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(logic [15:0] c, logic [15:0] a0, logic [15:0] a1, logic [15:0] a4,
                       logic [15:0] a5, logic [15:0] a8, logic [15:0] a9,
                       logic [15:0] kx, logic [15:0] ky, logic [15:0] dc, logic [15:0] sc);
    int sx, sy, ex, ey, stx, sty, nx, ny, x, y, db, sb, sa;
    logic [15:0] v;
    bit fill;
    fill = c[15:11] == 5'd2;
    sx = fill ? int'($signed(a0)) : int'($signed(a4));
    sy = fill ? int'($signed(a1)) : int'($signed(a5));
    ex = fill ? int'($signed(a4)) : int'($signed(a8));
    ey = fill ? int'($signed(a5)) : int'($signed(a9));
    stx = (ex >= sx) ? 1 : -1; sty = (ey >= sy) ? 1 : -1;
    nx = (ex - sx) * stx + 1; ny = (ey - sy) * sty + 1;
    db = int'(dc[6:0]) << 15;
    sb = (int'(sc[6:0]) << 15) + (int'(sc[15:13]) << 12);
    eq.delete(); ev.delete();
    for (int j = 0; j < ny; j++)
      for (int i = 0; i < nx; i++) begin
        x = sx + i * stx; y = sy + j * sty;
        if (x >= 0 && x <= int'($signed(kx)) && y >= 0 && y <= int'($signed(ky))) begin
          sa = (sb + bswz(int'(a0) + i, int'(a1) + j)) & ((1 << AW) - 1);
          v = fill ? a8 : bg(sa);
          if (fill || !c[9] || v != 0) begin
            eq.push_back((db + bswz(x, y)) & ((1 << AW) - 1));
            ev.push_back(v);
          end
        end
      end
  endtask

  task automatic op(string tag, logic [15:0] c, logic [15:0] a0, logic [15:0] a1,
                    logic [15:0] a4, logic [15:0] a5, logic [15:0] a8, logic [15:0] a9,
                    logic [15:0] kx, logic [15:0] ky, logic [15:0] dc, logic [15:0] sc,
                    bit poke);
    int n, bad_ord, bad_val;
    mem.delete(); wq.delete();
    model(c, a0, a1, a4, a5, a8, a9, kx, ky, dc, sc);
    @(negedge clk);
    cmd = c; prm0 = a0; prm1 = a1; prm4 = a4; prm5 = a5; prm8 = a8; prm9 = a9;
    clip_x = kx; clip_y = ky; dst_cfg = dc; src_cfg = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", {tag, " busy after start"}, int'(busy), 1);
    if (poke) begin
      @(negedge clk);
      cmd = 16'h1000; prm0 = 0; prm1 = 0; prm4 = 3; prm5 = 3; prm8 = 16'hBEEF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R8", {tag, " completes"}, int'(done), 1);
    chk("R8", {tag, " idle at done"}, int'(busy), 0);
    @(negedge clk);
    chk("R8", {tag, " done one cycle"}, int'(done), 0);
    chk(tag, "write count", wq.size(), eq.size());
    bad_ord = 0; bad_val = 0;
    for (int i = 0; i < eq.size() && i < wq.size(); i++) begin
      if (wq[i] != eq[i]) bad_ord++;
      if (!mem.exists(eq[i]) || mem[eq[i]] != ev[i]) bad_val++;
    end
    chk(tag == "R4" ? "R4" : "R7", {tag, " write order mismatches"}, bad_ord, 0);
    chk(tag, "pixel value mismatches", bad_val, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int u;
    logic [15:0] c;
    u = $urandom(20231);
    repeat (3) @(negedge clk);
    chk("R8", "reset busy", int'(busy), 0);
    chk("R8", "reset done", int'(done), 0);
    chk("R8", "reset wr_en", int'(wr_en), 0);
    chk("R8", "reset rd_en", int'(rd_en), 0);
    rst_n = 1'b1;
    // R3 fill, forward
    op("R3", 16'h1000, 2, 1, 6, 3, 16'h1234, 0, 100, 100, 16'h0001, 16'h0004, 0);
    // R1 fill across tile borders
    op("R1", 16'h1000, 12, 14, 35, 33, 16'h0F0F, 0, 200, 200, 16'h0002, 16'h0004, 0);
    // R4 fill mirrored both axes
    op("R4", 16'h1000, 20, 9, 14, 2, 16'h4321, 0, 100, 100, 16'h0001, 16'h0004, 0);
    // R5 partial clip with negative start
    op("R5", 16'h1000, 16'hFFFD, 16'hFFFE, 10, 8, 16'h7777, 0, 5, 4, 16'h0001, 16'h0004, 0);
    // R5 negative clip: nothing written
    op("R5", 16'h1000, 0, 0, 4, 4, 16'h5555, 0, 16'hFFFF, 10, 16'h0001, 16'h0004, 0);
    // R3 single pixel
    op("R3", 16'h1000, 7, 7, 7, 7, 16'hAAAA, 0, 7, 7, 16'h0003, 16'h0004, 0);
    // R6 fill of zero color with transparency bit set still writes
    op("R6", 16'h1200, 1, 1, 4, 2, 16'h0000, 0, 50, 50, 16'h0001, 16'h0004, 0);
    // R11 R2 copy opaque
    op("R11", 16'h0000, 3, 5, 0, 0, 17, 9, 100, 100, 16'h0001, 16'h2005, 0);
    // R6 copy transparent
    op("R6", 16'h0200, 0, 0, 2, 2, 22, 12, 100, 100, 16'h0002, 16'hE004, 0);
    // R4 copy mirrored, source upward
    op("R4", 16'h0000, 1, 2, 19, 8, 4, 1, 100, 100, 16'h0001, 16'h6006, 0);
    // R10 other opcode selects copy
    op("R10", 16'hF800, 5, 5, 3, 3, 9, 6, 100, 100, 16'h0001, 16'h0007, 0);
    // R2 copy with clipped destination
    op("R2", 16'h0000, 0, 0, 16'hFFFE, 1, 12, 7, 8, 5, 16'h0003, 16'hA005, 0);
    // R9 start while busy ignored
    op("R9", 16'h1000, 0, 0, 15, 6, 16'h3C3C, 0, 100, 100, 16'h0001, 16'h0004, 1);
    op("R9", 16'h0200, 0, 0, 0, 0, 14, 5, 100, 100, 16'h0002, 16'h0005, 1);
    for (int k = 0; k < 20; k++) begin
      c = ($urandom % 2) ? 16'h1000 : 16'h0000;
      if ($urandom % 2) c[9] = 1'b1;
      op(c[12] ? "R3" : "R11", c,
         16'($urandom % 40), 16'($urandom % 40),
         16'(int'($urandom % 50) - 5), 16'(int'($urandom % 40) - 5),
         16'($urandom % 60), 16'($urandom % 40),
         16'($urandom % 48), 16'($urandom % 36),
         16'(1 + $urandom % 3), {3'($urandom), 6'd0, 7'(4 + $urandom % 4)}, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule